// File: doc/BRIEF.md
# Deadlock Backoff Request Timer

This block sits in a bridge that connects a host bus to a local bus. It watches for a likely deadlock. One side of the deadlock is a host-side master that wants the local bus and has not been granted it. The other side is a local master whose direct access toward the host bus is stalled. The local master counts as stalled when it is doing a direct read, or when it is doing a direct write while the bridge's direct-master write FIFO is full.

While both sides hold at once, a programmable timer counts clock cycles. When the programmed count is reached, the block raises a backoff request. This output tells the local master to give up the local bus so that the host-side access can complete.

Only the pass-through (direct) access signals feed the detector. Block-transfer engines and message-register paths have no input here, so they can never start the timer. A limit of zero turns detection off.

Top module: `backoff_timer`

## Requirements
- R1: The host-side condition is true only while `hostReqPending` is 1 and `localHoldAck` is 0. While `localHoldAck` is 1, `backoffReq` is 0 after the next clock edge.
- R2: A direct read (`directRead` = 1) satisfies the local-side condition on its own, whatever the value of `wrFifoFull`.
- R3: A direct write (`directWrite` = 1) satisfies the local-side condition only while `wrFifoFull` is 1. A direct write with the FIFO not full does not count toward the timer.
- R4: With `timerLimit` = L > 0, `backoffReq` becomes 1 after the L-th consecutive rising clock edge at which both conditions are sampled true. It stays 1 while both conditions keep holding.
- R5: If either condition is false at any clock edge before expiry, the count restarts. L further consecutive edges with both conditions true are then needed.
- R6: Once asserted, `backoffReq` returns to 0 at the first clock edge at which either condition is sampled false.
- R7: While `timerLimit` is 0, `backoffReq` stays 0 regardless of the conditions.
- R8: While `rstN` is low, and after its release, `backoffReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReqPending | input | 1 | A host-side master is trying to reach local memory or I/O |
| localHoldAck | input | 1 | The local bus has been granted to the bridge |
| directRead | input | 1 | The local master is performing a direct read of the host bus |
| directWrite | input | 1 | The local master is performing a direct write to the host bus |
| wrFifoFull | input | 1 | The direct-master write FIFO cannot accept another cycle |
| timerLimit | input | CNT_W | Backoff delay in clock cycles; 0 disables detection |
| backoffReq | output | 1 | Backoff request to the local master |

## Verification
The hardest situation to reach is a near-expiry interruption. The count must reach L-1, a single cycle must then break one condition, and the test must show that a full L more cycles are needed afterwards. The bench builds this deliberately: it holds all inputs steady for L-1 edges, drops one condition for exactly one edge, and then counts edges again.

The bench also sweeps every combination of the five condition inputs against several small limits and hold lengths. This covers the write-without-full-FIFO case and the zero-limit case.

// File: rtl/backoff_timer_pkg.sv
package backoff_timer_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // restart count and drop request
    logic advance;  // both conditions hold this cycle
  } bkStrobe_t;
endpackage

// File: rtl/backoff_timer_ctrl.sv
module backoff_timer_ctrl
  import backoff_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             hostReqPending,
  input  logic             localHoldAck,
  input  logic             directRead,
  input  logic             directWrite,
  input  logic             wrFifoFull,
  input  logic [CNT_W-1:0] timerLimit,
  output bkStrobe_t        strb
);
  logic hostStuck;
  logic localStuck;
  logic armed;

  always_comb begin
    hostStuck   = hostReqPending && !localHoldAck;
    localStuck  = directRead || (directWrite && wrFifoFull);
    armed       = (timerLimit != '0);
    strb.advance = hostStuck && localStuck && armed;
    strb.clear   = !strb.advance;
  end
endmodule

// File: rtl/backoff_timer_dp.sv
module backoff_timer_dp
  import backoff_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  bkStrobe_t        strb,
  input  logic [CNT_W-1:0] timerLimit,
  output logic             expired
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] count;
  logic [EXT_W-1:0] nextCount;
  logic [EXT_W-1:0] limitExt;

  always_comb begin
    nextCount = {1'b0, count} + EXT_W'(1);
    limitExt  = {1'b0, timerLimit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (strb.clear) begin
      count   <= '0;
      expired <= 1'b0;
    end else if (strb.advance) begin
      if ({1'b0, count} < limitExt) count <= nextCount[CNT_W-1:0];
      expired <= (nextCount >= limitExt);
    end
  end

  // R5: a clear strobe always leaves the request low
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !expired);
endmodule

// File: rtl/backoff_timer.sv
module backoff_timer
  import backoff_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostReqPending,
  input  logic             localHoldAck,
  input  logic             directRead,
  input  logic             directWrite,
  input  logic             wrFifoFull,
  input  logic [CNT_W-1:0] timerLimit,
  output logic             backoffReq
);
  bkStrobe_t strb;

  backoff_timer_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .hostReqPending(hostReqPending),
    .localHoldAck  (localHoldAck),
    .directRead    (directRead),
    .directWrite   (directWrite),
    .wrFifoFull    (wrFifoFull),
    .timerLimit    (timerLimit),
    .strb          (strb)
  );

  backoff_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .timerLimit(timerLimit),
    .expired   (backoffReq)
  );

  assert_hold_ack_R1: assert property (@(posedge clk) disable iff (!rstN)
    localHoldAck |=> !backoffReq);

  assert_write_not_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (directWrite && !wrFifoFull && !directRead) |=> !backoffReq);

  assert_rise_needs_both_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(backoffReq) |-> $past(hostReqPending && !localHoldAck &&
                                (directRead || (directWrite && wrFifoFull))));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!hostReqPending || (!directRead && !directWrite)) |=> !backoffReq);

  assert_zero_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (timerLimit == '0) |=> !backoffReq);

  // R8: request low immediately after a reset edge
  assert_reset_low_R8: assert property (@(posedge clk)
    !rstN |=> !backoffReq);
endmodule

// File: tb/backoff_timer_tb_top.sv
module backoff_timer_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostReqPending = 1'b0;
  logic localHoldAck = 1'b0;
  logic directRead = 1'b0;
  logic directWrite = 1'b0;
  logic wrFifoFull = 1'b0;
  logic [CNT_W-1:0] timerLimit = '0;
  logic backoffReq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  backoff_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .hostReqPending(hostReqPending),
    .localHoldAck(localHoldAck), .directRead(directRead),
    .directWrite(directWrite), .wrFifoFull(wrFifoFull),
    .timerLimit(timerLimit), .backoffReq(backoffReq));

  task automatic check(input string tag, input logic exp);
    nChecks++;
    if (backoffReq !== exp) begin
      nFails++;
      $display("FAIL %s: backoffReq=%b expected=%b t=%0t", tag, backoffReq, exp, $time);
    end
  endtask

  task automatic setIn(input logic [4:0] p);
    {hostReqPending, localHoldAck, directRead, directWrite, wrFifoFull} = p;
  endtask

  function automatic logic bothOf(input logic [4:0] p);
    return p[4] && !p[3] && (p[2] || (p[1] && p[0]));
  endfunction

  function automatic string tagOf(input logic [4:0] p, input int lim);
    if (lim == 0) return "R7";
    if (p[3]) return "R1";
    if (!p[4]) return "R1";
    if (p[2]) return "R2";
    if (p[1]) return "R3";
    return "R4";
  endfunction

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", 1'b0);

    // Sweep all condition combinations, limits and hold lengths
    for (int lim = 0; lim <= 4; lim++) begin
      timerLimit = CNT_W'(lim);
      for (int p = 0; p < 32; p++) begin
        setIn(5'b00000);
        @(negedge clk);
        setIn(5'(p));
        for (int k = 1; k <= 6; k++) begin
          @(negedge clk);
          check(tagOf(5'(p), lim), bothOf(5'(p)) && lim != 0 && k >= lim);
        end
        setIn(5'b00000);
        @(negedge clk);
        check("R6", 1'b0);
      end
    end

    // R5: interruption one cycle before expiry, for each limit
    for (int lim = 2; lim <= 6; lim++) begin
      timerLimit = CNT_W'(lim);
      setIn(5'b10100);
      for (int k = 1; k < lim; k++) @(negedge clk);
      check("R5", 1'b0);
      localHoldAck = 1'b1;  // break host-side condition for one edge
      @(negedge clk);
      check("R5", 1'b0);
      localHoldAck = 1'b0;
      for (int k = 1; k <= lim; k++) begin
        @(negedge clk);
        check("R5", k >= lim);
      end
      // R6: drop the local-side condition only
      directRead = 1'b0;
      @(negedge clk);
      check("R6", 1'b0);
    end

    // R3: write with full FIFO, then FIFO frees while asserted
    timerLimit = CNT_W'(3);
    setIn(5'b10011);
    repeat (3) @(negedge clk);
    check("R3", 1'b1);
    wrFifoFull = 1'b0;
    @(negedge clk);
    check("R3", 1'b0);

    // R7: limit forced to zero while asserted
    setIn(5'b10100);
    repeat (3) @(negedge clk);
    check("R4", 1'b1);
    timerLimit = '0;
    @(negedge clk);
    check("R7", 1'b0);

    // R8: reset while asserted
    timerLimit = CNT_W'(1);
    @(negedge clk);
    check("R4", 1'b1);
    rstN = 1'b0;
    @(negedge clk);
    check("R8", 1'b0);
    rstN = 1'b1;
    setIn(5'b00000);
    @(negedge clk);
    check("R8", 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule